// File: doc/BRIEF.md
# Performance Event Counter Bank with Dual Write Paths

This block holds a small set of event counters, each `CNT_W` bits wide, that software reaches through a plain register port. A port access is an address, a 64-bit write word and a write strobe. Read data comes back combinationally, and a fault flag reports a rejected write one cycle later. There are two groups of counters: general counters and fixed-role counters. Each counter adds one on any cycle when its own event line is high. It wraps from all-ones to zero, and that wrap produces a one-cycle overflow pulse.

A general counter can be written in two ways. The narrow path takes only the low 32 data bits and loads their sign extension. The wide path is an alias address range that loads all `CNT_W` bits and rejects any write that sets a bit above the counter width. The wide path exists only while the full-width capability input is high. Fixed-role counters have a single address each, and the same capability input decides which of the two rules applies to them. A read-only identity word reports the counter width and the counter count.

Top module: `pmc_bank`

## Requirements
- R1: A write to a general counter's narrow address (0x0C1 + i) loads the 64-bit sign extension of data[31:0], truncated to `CNT_W` bits. It never raises the fault flag, whatever data[63:32] holds and whatever the capability level.
- R2: With `fw_cap_i` = 1 (it carries bit 13 of the capability register), a write to alias address 0x4C1 + i loads data[`CNT_W`-1:0] into general counter i.
- R3: An alias write with `fw_cap_i` = 1 and any data bit in [63:`CNT_W`] set leaves the counter unchanged. It raises `fault_o` for exactly the one cycle after the write.
- R4: With `fw_cap_i` = 0, an alias write raises `fault_o` and changes nothing, and an alias read returns zero.
- R5: With `fw_cap_i` = 0, a write to fixed counter j (address 0x309 + j, counter index `N_GP` + j) loads the sign extension of data[31:0] and never faults.
- R6: With `fw_cap_i` = 1, a fixed counter write loads data[`CNT_W`-1:0], or faults and leaves the counter unchanged when a reserved bit [63:`CNT_W`] is set.
- R7: Address 0x00A reads an identity word with `CNT_W` in bits [23:16], the total counter count in bits [15:8] and zeros elsewhere. Writes to it change nothing and do not fault.
- R8: A counter adds one on each clock edge at which its event input is high.
- R9: On the step from 2^`CNT_W`-1 to 0, the counter's `ovf_o` bit is high for exactly the one cycle in which the counter reads zero.
- R10: When a write and an event reach the same counter in the same cycle, the written value is loaded and no overflow pulse is produced.
- R11: A counter read through its narrow, alias or fixed address returns its value zero-extended to 64 bits. The narrow and alias reads of one counter agree.
- R12: While reset is asserted, and after its release, all counters read zero and `fault_o` and `ovf_o` are low.
- R13: `CNT_W` outside 32..48 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fw_cap_i | input | 1 | Full-width write capability (capability register bit 13) |
| ev_i | input | N_GP+N_FIX | Per-counter event inputs |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 64 | Write data |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 64 | Read data for addr_i |
| fault_o | output | 1 | One-cycle fault pulse after a rejected write |
| ovf_o | output | N_GP+N_FIX | Per-counter overflow pulse |

## Verification
The bench checks narrow writes whose upper data word holds garbage and whose low word has bit 31 set. A design that zero-extended, or that faulted on the upper word, would show the wrong count or a spurious fault. It sets reserved bits just above the width and at bit 63 on alias and fixed writes with the capability high. A broken reserved check would load a corrupt value or stay silent. It issues alias accesses with the capability low, drives a counter across its wrap and watches the overflow pulse cycle by cycle, and lands a write and an event on the same edge. A design with the wrong priority would show the incremented value or a stray overflow pulse.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  // Kind of register an address selects
  typedef enum logic [2:0] {
    HIT_NONE,
    HIT_GP,
    HIT_ALIAS,
    HIT_FIX,
    HIT_ID
  } hit_e;

  localparam int unsigned DATA_W   = 64;
  localparam int unsigned MIN_CNTW = 32;
  localparam int unsigned MAX_CNTW = 48;
endpackage

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int unsigned CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, wrap_d, cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_d = 1'b0;
    cnt_en = ld_i | ev_i;
    if (ld_i) begin
      cnt_d = ld_val_i;
    end else if (ev_i) begin
      cnt_d  = cnt_q + 1'b1;
      wrap_d = &cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      ovf_q <= wrap_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i && !ld_i) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (cnt_q == $past(ld_val_i)) && !ovf_q);

  a_r9_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> cnt_q == '0);

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_i && !ld_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pmc_decode.sv
module pmc_decode
  import pmc_pkg::*;
#(
  parameter int unsigned N_GP   = 4,
  parameter int unsigned N_FIX  = 3,
  parameter int unsigned CNT_W  = 40,
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] GP_BASE    = 12'h0C1,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 12'h4C1,
  parameter logic [ADDR_W-1:0] FIX_BASE   = 12'h309,
  parameter logic [ADDR_W-1:0] ID_ADDR    = 12'h00A,
  localparam int unsigned N_CNT = N_GP + N_FIX
) (
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic                   wr_i,
  input  logic                   fw_en_i,
  input  logic [N_CNT*CNT_W-1:0] cnt_flat_i,
  output logic [N_CNT-1:0]       ld_en_o,
  output logic [CNT_W-1:0]       ld_val_o,
  output logic                   fault_o,
  output logic [DATA_W-1:0]      rdata_o
);
  localparam int unsigned IDX_W = (N_CNT > 1) ? $clog2(N_CNT) : 1;
  localparam logic [DATA_W-1:0] ID_WORD =
    {40'd0, 8'(CNT_W), 8'(N_CNT), 8'd0};

  hit_e             hit;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] sel_cnt, sext_val, full_val;
  logic             rsvd_set, is_cnt, legal, wr_go;

  // Address match
  always_comb begin
    hit = HIT_NONE;
    idx = '0;
    for (int i = 0; i < N_GP; i++) begin
      if (addr_i == GP_BASE + ADDR_W'(i)) begin
        hit = HIT_GP;
        idx = IDX_W'(i);
      end
      if (addr_i == ALIAS_BASE + ADDR_W'(i)) begin
        hit = HIT_ALIAS;
        idx = IDX_W'(i);
      end
    end
    for (int j = 0; j < N_FIX; j++) begin
      if (addr_i == FIX_BASE + ADDR_W'(j)) begin
        hit = HIT_FIX;
        idx = IDX_W'(N_GP + j);
      end
    end
    if (addr_i == ID_ADDR) hit = HIT_ID;
  end

  assign sel_cnt  = cnt_flat_i[idx*CNT_W +: CNT_W];
  assign rsvd_set = |wdata_i[DATA_W-1:CNT_W];
  assign sext_val = CNT_W'({{32{wdata_i[31]}}, wdata_i[31:0]});
  assign full_val = wdata_i[CNT_W-1:0];

  // Write legality and load value
  always_comb begin
    is_cnt   = 1'b0;
    legal    = 1'b1;
    ld_val_o = sext_val;
    unique case (hit)
      HIT_GP: is_cnt = 1'b1;
      HIT_ALIAS: begin
        is_cnt   = 1'b1;
        legal    = fw_en_i && !rsvd_set;
        ld_val_o = full_val;
      end
      HIT_FIX: begin
        is_cnt = 1'b1;
        if (fw_en_i) begin
          legal    = !rsvd_set;
          ld_val_o = full_val;
        end
      end
      default: ;
    endcase
  end

  assign wr_go   = wr_i && is_cnt && legal;
  assign fault_o = wr_i && is_cnt && !legal;

  always_comb begin
    for (int k = 0; k < N_CNT; k++) ld_en_o[k] = wr_go && (idx == IDX_W'(k));
  end

  // Read mux
  always_comb begin
    unique case (hit)
      HIT_GP, HIT_FIX: rdata_o = DATA_W'(sel_cnt);
      HIT_ALIAS:       rdata_o = fw_en_i ? DATA_W'(sel_cnt) : '0;
      HIT_ID:          rdata_o = ID_WORD;
      default:         rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int unsigned N_GP   = 4,
  parameter int unsigned N_FIX  = 3,
  parameter int unsigned CNT_W  = 40,
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] GP_BASE    = 12'h0C1,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 12'h4C1,
  parameter logic [ADDR_W-1:0] FIX_BASE   = 12'h309,
  parameter logic [ADDR_W-1:0] ID_ADDR    = 12'h00A,
  localparam int unsigned N_CNT = N_GP + N_FIX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fw_cap_i,
  input  logic [N_CNT-1:0]  ev_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [63:0]       wdata_i,
  input  logic              wr_i,
  output logic [63:0]       rdata_o,
  output logic              fault_o,
  output logic [N_CNT-1:0]  ovf_o
);
  initial begin : a_r13_width_range
    assert (CNT_W >= MIN_CNTW && CNT_W <= MAX_CNTW)
      else $error("counter width %0d outside %0d..%0d", CNT_W, MIN_CNTW, MAX_CNTW);
  end

  // Reset: asynchronous assertion, synchronous release
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [N_CNT*CNT_W-1:0] cnt_flat;
  logic [N_CNT-1:0]       ld_en;
  logic [CNT_W-1:0]       ld_val;
  logic                   fault_d, fault_q;

  pmc_decode #(
    .N_GP(N_GP), .N_FIX(N_FIX), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
    .GP_BASE(GP_BASE), .ALIAS_BASE(ALIAS_BASE),
    .FIX_BASE(FIX_BASE), .ID_ADDR(ID_ADDR)
  ) u_dec (
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .wr_i      (wr_i),
    .fw_en_i   (fw_cap_i),
    .cnt_flat_i(cnt_flat),
    .ld_en_o   (ld_en),
    .ld_val_o  (ld_val),
    .fault_o   (fault_d),
    .rdata_o   (rdata_o)
  );

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    pmc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_sync),
      .ev_i    (ev_i[g]),
      .ld_i    (ld_en[g]),
      .ld_val_i(ld_val),
      .cnt_o   (cnt_flat[g*CNT_W +: CNT_W]),
      .ovf_o   (ovf_o[g])
    );
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) fault_q <= 1'b0;
    else           fault_q <= fault_d;
  end
  assign fault_o = fault_q;

  a_r3_fault_follows_write: assert property (@(posedge clk) disable iff (!rst_sync)
    fault_o |-> $past(wr_i));

  a_r4_alias_reads_zero: assert property (@(posedge clk) disable iff (!rst_sync)
    (!fw_cap_i && addr_i >= ALIAS_BASE && addr_i < ALIAS_BASE + ADDR_W'(N_GP))
      |-> rdata_o == '0);

  a_r12_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_sync) |-> !fault_o && ovf_o == '0);
endmodule

// File: tb/pmc_bank_test.sv
module pmc_bank_test;
  localparam int unsigned NG = 4;
  localparam int unsigned NF = 3;
  localparam int unsigned N  = NG + NF;
  localparam int unsigned W  = 40;
  localparam logic [11:0] A_GP  = 12'h0C1;
  localparam logic [11:0] A_AL  = 12'h4C1;
  localparam logic [11:0] A_FX  = 12'h309;
  localparam logic [11:0] A_ID  = 12'h00A;
  localparam logic [63:0] ONES  = (64'd1 << W) - 64'd1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fw_cap = 1'b0;
  logic [N-1:0]  ev = '0;
  logic [11:0]   addr = '0;
  logic [63:0]   wdata = '0;
  logic          wr = 1'b0;
  logic [63:0]   rdata;
  logic          fault;
  logic [N-1:0]  ovf;

  always #5 clk = ~clk;

  pmc_bank uut (
    .clk(clk), .rst_n(rst_n), .fw_cap_i(fw_cap), .ev_i(ev),
    .addr_i(addr), .wdata_i(wdata), .wr_i(wr),
    .rdata_o(rdata), .fault_o(fault), .ovf_o(ovf)
  );

  typedef struct {
    int          kind;   // 0 read data, 1 fault flag, 2 overflow vector
    logic [63:0] exp;
    string       req;
  } item_t;

  item_t sb[$];
  item_t it;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [63:0] act;

  // Monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      it = sb.pop_front();
      case (it.kind)
        0:       act = rdata;
        1:       act = {63'd0, fault};
        default: act = 64'(ovf);
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(input int k, input logic [63:0] e, input string r);
    item_t x;
    x.kind = k; x.exp = e; x.req = r;
    sb.push_back(x);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [63:0] d,
                        input logic exp_fault, input string r);
    addr = a; wdata = d; wr = 1'b1;
    step();
    wr = 1'b0;
    push(1, {63'd0, exp_fault}, r);
  endtask

  task automatic rd_reg(input logic [11:0] a, input logic [63:0] e, input string r);
    addr = a;
    push(0, e, r);
    step();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    push(2, 64'd0, "R12 ovf in reset");
    push(1, 64'd0, "R12 fault in reset");
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    rd_reg(A_GP, 64'd0, "R12 counter after reset");
    push(2, 64'd0, "R12 ovf after reset");

    // Narrow path, capability low, junk upper word
    wr_reg(A_GP, 64'h1234_5678_8000_0001, 1'b0, "R1 no fault");
    rd_reg(A_GP, 64'h0000_00FF_8000_0001, "R1 sign extension / R11 zero-extended read");
    wr_reg(A_GP + 12'd1, 64'hDEAD_BEEF_7000_0000, 1'b0, "R1 no fault positive");
    rd_reg(A_GP + 12'd1, 64'h0000_0000_7000_0000, "R1 positive load");

    // Alias with capability low
    wr_reg(A_AL + 12'd1, 64'd5, 1'b1, "R4 alias write faults");
    rd_reg(A_GP + 12'd1, 64'h0000_0000_7000_0000, "R4 counter unchanged");
    rd_reg(A_AL + 12'd1, 64'd0, "R4 alias read zero");
    push(1, 64'd0, "R3 fault lasts one cycle");

    // Alias with capability high
    fw_cap = 1'b1;
    wr_reg(A_AL + 12'd2, 64'h0000_00AB_CDEF_0123, 1'b0, "R2 alias write ok");
    rd_reg(A_GP + 12'd2, 64'h0000_00AB_CDEF_0123, "R2 full-width load");
    rd_reg(A_AL + 12'd2, 64'h0000_00AB_CDEF_0123, "R11 alias read matches");
    wr_reg(A_AL + 12'd2, 64'h0000_0100_0000_0007, 1'b1, "R3 bit W set faults");
    rd_reg(A_GP + 12'd2, 64'h0000_00AB_CDEF_0123, "R3 counter unchanged");
    wr_reg(A_AL + 12'd2, 64'h8000_0000_0000_0009, 1'b1, "R3 bit 63 set faults");
    rd_reg(A_GP + 12'd2, 64'h0000_00AB_CDEF_0123, "R3 counter unchanged bit63");
    wr_reg(A_GP + 12'd3, 64'hFFFF_0000_FFFF_FFF0, 1'b0, "R1 narrow no fault cap on");
    rd_reg(A_GP + 12'd3, 64'h0000_00FF_FFFF_FFF0, "R1 sign extension cap on");

    // Fixed counters
    fw_cap = 1'b0;
    wr_reg(A_FX, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, "R5 fixed narrow no fault");
    rd_reg(A_FX, 64'h0000_00FF_FFFF_FFFE, "R5 fixed sign extension");
    fw_cap = 1'b1;
    wr_reg(A_FX + 12'd1, 64'h0000_0012_3456_789A, 1'b0, "R6 fixed full width ok");
    rd_reg(A_FX + 12'd1, 64'h0000_0012_3456_789A, "R6 fixed full load");
    wr_reg(A_FX + 12'd1, 64'h0000_2000_0000_0001, 1'b1, "R6 fixed reserved faults");
    rd_reg(A_FX + 12'd1, 64'h0000_0012_3456_789A, "R6 fixed unchanged");

    // Identity word
    rd_reg(A_ID, 64'h0000_0000_0028_0700, "R7 identity word");
    wr_reg(A_ID, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R7 identity write no fault");
    rd_reg(A_ID, 64'h0000_0000_0028_0700, "R7 identity unchanged");

    // Counting
    wr_reg(A_GP, 64'd10, 1'b0, "R8 preload");
    ev[0] = 1'b1;
    repeat (5) step();
    ev[0] = 1'b0;
    rd_reg(A_GP, 64'd15, "R8 five events");

    // Wrap and overflow pulse
    wr_reg(A_AL, ONES - 64'd1, 1'b0, "R9 preload near wrap");
    ev[0] = 1'b1;
    step();
    push(2, 64'd0, "R9 no pulse at all-ones");
    step();
    ev[0] = 1'b0;
    push(2, 64'd1, "R9 pulse on wrap");
    rd_reg(A_GP, 64'd0, "R9 wrapped to zero");
    push(2, 64'd0, "R9 pulse is one cycle");

    // Write beats event in same cycle
    fw_cap = 1'b0;
    wr_reg(A_FX + 12'd2, 64'h0000_0000_FFFF_FFFF, 1'b0, "R10 preload all ones");
    addr = A_FX + 12'd2; wdata = 64'd5; wr = 1'b1; ev[6] = 1'b1;
    step();
    wr = 1'b0; ev[6] = 1'b0;
    push(2, 64'd0, "R10 no overflow on write+event");
    rd_reg(A_FX + 12'd2, 64'd5, "R10 write wins");

    step();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule